// File: doc/BRIEF.md
# Byte-Handshake I2C Master Controller

This block is an I2C bus master that moves one byte per software handshake. Software loads a byte into the data register and writes mode bits into the status register. The block then generates the bus waveform for that byte and its acknowledge clock. When the byte is finished it raises a pending flag and holds SCL low, which stretches the bus, until software clears the flag. Clearing the flag starts the next action: another byte, a repeated START or a STOP.

The bit rate comes from a prescaler of 16 or 512 followed by a 4-bit divisor. Each SCL period is split into four equal quarters. SDA changes only while SCL is low, except on the START and STOP edges. The bus pins are open-drain: the block only decides when to pull each line low, and it reads the resolved SDA level back.

Registers sit on a small port with a 2-bit index:

| Index | Register |
|-------|----------|
| 0 | control |
| 1 | status |
| 2 | data |
| 3 | own address |

Reads are combinational.

Top module: `bhm_i2c_master`

## Requirements
- R1: After reset all four registers read 0, irq is low, and neither bus line is pulled low. The register indices are control = 0, status = 1, data = 2, own address = 3.
- R2: The SCL period is P*(D+1) clock cycles, and SCL stays high for half of it. D is control bits 3:0. P is 16 when control bit 6 is 0 and 512 when it is 1.
- R3: A START is requested by a status write with bit 7 set, bit 5 set and bit 4 set. If the bus is idle, the block pulls SDA low while SCL is high. It then sends the data register byte MSB first. Status bit 5 reads 1 from that write until the STOP finishes.
- R4: Control bit 4 (pending) sets when a byte's ninth (acknowledge) clock ends. SCL is pulled low for as long as pending is set. The irq output equals pending AND control bit 5.
- R5: Status bit 0 holds the SDA level sampled during the last acknowledge clock: 1 means NACK, 0 means ACK.
- R6: A control write with bit 4 = 0 while pending is set clears pending and launches the next action. A control write with bit 4 = 1 never sets pending and launches nothing.
- R7: The status mode field is bits 7:6. With mode 11, a launch transmits the data register byte. With mode 10, a launch receives 8 bits MSB first into the data register. On the ninth clock of a received byte the master pulls SDA low (ACK) if control bit 7 was 1 in the launching write, and releases it (NACK) otherwise.
- R8: A START request made while pending is set takes effect when pending is cleared. The block then produces a repeated START followed by the data register byte.
- R9: A status write with bit 7 set, bit 5 clear and bit 4 set while the bus is busy, followed by a pending clear, produces a STOP: SDA rises while SCL is high. Afterwards status bit 5 reads 0 and pending stays 0.
- R10: A START request with status bit 4 = 0 is ignored. The bus stays idle and status bit 5 stays 0.
- R11: If a received byte completes in the same cycle as a software write to the data register, the received byte wins.
- R12: The own-address register stores and reads back any 8-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register index |
| reg_wr | input | 1 | Write strobe for the indexed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the indexed register |
| irq | output | 1 | Pending AND interrupt enable |
| scl_pull_low | output | 1 | Pull SCL low when 1 |
| sda_pull_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
Completion of a received byte and a software write to the data register can fall in the same clock cycle, because both write the data register.

The bench provokes this collision by writing a marker value to the data register on every cycle while a byte is being received, and it stops only on the cycle after irq rises. The last write therefore lands on the very edge that sets pending. The register is then judged on the slave's byte, never the marker.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

  typedef enum logic [3:0] {
    ENG_IDLE, ENG_HOLD, ENG_RSA, ENG_STB, ENG_STC, ENG_STD,
    ENG_BIT, ENG_SP0, ENG_SP1, ENG_SP2, ENG_SP3
  } eng_state_e;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_START = 2'd1,
    REQ_STOP  = 2'd2
  } launch_req_e;

  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
  localparam logic [1:0] IDX_DATA = 2'd2;
  localparam logic [1:0] IDX_OWN  = 2'd3;

  // Clock cycles in one quarter of an SCL period.
  function automatic int unsigned quarter_clocks(input int unsigned pre,
                                                 input int unsigned div);
    return (pre / 4) * (div + 1);
  endfunction

  // Clock cycles in a full SCL period.
  function automatic int unsigned scl_period(input int unsigned pre,
                                             input int unsigned div);
    return pre * (div + 1);
  endfunction

endpackage

// File: rtl/bhm_rate_gen.sv
module bhm_rate_gen
  import bhm_pkg::*;
#(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 512,
  parameter int unsigned DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_sel,
  input  logic [DIV_W-1:0] div,
  output logic             qtick
);
  localparam int unsigned Q_LO = PRE_LO / 4;
  localparam int unsigned Q_HI = PRE_HI / 4;
  localparam int unsigned PW   = (Q_HI > 1) ? $clog2(Q_HI) : 1;
  localparam int unsigned CW   = PW + DIV_W + 1;

  logic [PW-1:0]    pcnt;
  logic [DIV_W-1:0] dcnt;
  logic [PW-1:0]    pre_last;
  logic             pwrap;

  assign pre_last = pre_sel ? PW'(Q_HI - 1) : PW'(Q_LO - 1);
  assign pwrap    = (pcnt >= pre_last);
  assign qtick    = run && pwrap && (dcnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (!run) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (pwrap) begin
      pcnt <= '0;
      dcnt <= (dcnt >= div) ? '0 : dcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // Independent cycle count between quarter ticks, for the length check.
  logic [CW-1:0]    chk_cnt;
  logic             chk_clean;
  logic             cfg_sel_q;
  logic [DIV_W-1:0] cfg_div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_cnt   <= '0;
      chk_clean <= 1'b1;
      cfg_sel_q <= 1'b0;
      cfg_div_q <= '0;
    end else begin
      cfg_sel_q <= pre_sel;
      cfg_div_q <= div;
      if (!run) begin
        chk_cnt   <= '0;
        chk_clean <= 1'b1;
      end else begin
        if (qtick) chk_cnt <= '0;
        else       chk_cnt <= chk_cnt + 1'b1;
        if ((pre_sel != cfg_sel_q) || (div != cfg_div_q)) chk_clean <= 1'b0;
        else if (qtick) chk_clean <= 1'b1;
      end
    end
  end

  assert_quarter_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (qtick && chk_clean && (pre_sel == cfg_sel_q) && (div == cfg_div_q)) |->
    ((32'(chk_cnt) + 32'd1) ==
     quarter_clocks(pre_sel ? PRE_HI : PRE_LO, 32'(div))));

endmodule

// File: rtl/bhm_bit_engine.sv
module bhm_bit_engine
  import bhm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qtick,
  input  logic       cmd_start,
  input  logic       cmd_byte,
  input  logic       cmd_stop,
  input  logic [7:0] cmd_data,
  input  logic       cmd_rx,
  input  logic       cmd_ack_en,
  input  logic       sda_in,
  output logic       run,
  output logic       busy,
  output logic       scl_low,
  output logic       sda_low,
  output logic       byte_done,
  output logic       done_rx,
  output logic [7:0] done_byte,
  output logic       done_ack,
  output logic       in_hold
);
  eng_state_e state;
  logic [1:0] qph;
  logic [3:0] bitn;
  logic [7:0] shreg;
  logic       rx_q, acken_q, ack_q, busy_q, sda_q;
  logic       stop_done;

  assign run       = (state != ENG_IDLE) && (state != ENG_HOLD);
  assign in_hold   = (state == ENG_HOLD);
  assign busy      = busy_q;
  assign sda_low   = sda_q;
  assign scl_low   = (state == ENG_HOLD) || (state == ENG_RSA) ||
                     (state == ENG_STD)  || (state == ENG_SP0) ||
                     (state == ENG_SP1)  || ((state == ENG_BIT) && !qph[1]);
  assign byte_done = (state == ENG_BIT) && (bitn == 4'd8) && (qph == 2'd3) && qtick;
  assign stop_done = (state == ENG_SP3) && qtick;
  assign done_rx   = rx_q;
  assign done_byte = shreg;
  assign done_ack  = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      qph     <= 2'd0;
      bitn    <= 4'd0;
      shreg   <= 8'h00;
      rx_q    <= 1'b0;
      acken_q <= 1'b0;
      ack_q   <= 1'b0;
      busy_q  <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: if (cmd_start) begin
          state  <= ENG_STB;
          shreg  <= cmd_data;
          rx_q   <= 1'b0;
          busy_q <= 1'b1;
          sda_q  <= 1'b0;
        end
        ENG_HOLD: begin
          if (cmd_start) begin
            state <= ENG_RSA;
            shreg <= cmd_data;
            rx_q  <= 1'b0;
            sda_q <= 1'b0;
          end else if (cmd_byte) begin
            state   <= ENG_BIT;
            qph     <= 2'd0;
            bitn    <= 4'd0;
            shreg   <= cmd_data;
            rx_q    <= cmd_rx;
            acken_q <= cmd_ack_en;
          end else if (cmd_stop) begin
            state <= ENG_SP0;
          end
        end
        ENG_RSA: if (qtick) state <= ENG_STB;
        ENG_STB: if (qtick) begin
          state <= ENG_STC;
          sda_q <= 1'b1;
        end
        ENG_STC: if (qtick) state <= ENG_STD;
        ENG_STD: if (qtick) begin
          state <= ENG_BIT;
          qph   <= 2'd0;
          bitn  <= 4'd0;
        end
        ENG_BIT: if (qtick) begin
          case (qph)
            2'd0: begin
              qph   <= 2'd1;
              sda_q <= (bitn == 4'd8) ? (rx_q & acken_q) : (~rx_q & ~shreg[7]);
            end
            2'd1: qph <= 2'd2;
            2'd2: begin
              qph <= 2'd3;
              if (bitn == 4'd8) ack_q <= sda_in;
              else              shreg <= {shreg[6:0], sda_in};
            end
            default: begin
              if (bitn == 4'd8) begin
                state <= ENG_HOLD;
              end else begin
                bitn <= bitn + 4'd1;
                qph  <= 2'd0;
              end
            end
          endcase
        end
        ENG_SP0: if (qtick) begin
          state <= ENG_SP1;
          sda_q <= 1'b1;
        end
        ENG_SP1: if (qtick) state <= ENG_SP2;
        ENG_SP2: if (qtick) begin
          state <= ENG_SP3;
          sda_q <= 1'b0;
        end
        ENG_SP3: if (qtick) begin
          state  <= ENG_IDLE;
          busy_q <= 1'b0;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // SDA may only move while SCL is high on the START and STOP edges.
  assert_sda_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ENG_BIT) && !scl_low && $past((state == ENG_BIT) && !scl_low))
      |-> $stable(sda_low));

  assert_start_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_low) && !scl_low && $past(!scl_low)) |-> (state == ENG_STC));

  assert_stop_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !busy);

endmodule

// File: rtl/bhm_i2c_master.sv
module bhm_i2c_master
  import bhm_pkg::*;
#(
  parameter int unsigned PRE_LO = 16,
  parameter int unsigned PRE_HI = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_pull_low,
  output logic       sda_pull_low,
  input  logic       sda_in
);
  localparam int unsigned DIV_W = 4;

  logic             ack_en, pre_sel, irq_en, pend, txrx, nack;
  logic [DIV_W-1:0] div;
  logic [1:0]       mode;
  logic [7:0]       data_q, own_q;
  launch_req_e      req;

  logic ctrl_wr, stat_wr, data_wr, own_wr;
  logic start_wr, stop_wr, launch;
  logic cmd_start, cmd_byte, cmd_stop;
  logic qtick, run, busy, byte_done, done_rx, done_ack, in_hold;
  logic [7:0] done_byte;

  assign ctrl_wr = reg_wr && (reg_addr == IDX_CTRL);
  assign stat_wr = reg_wr && (reg_addr == IDX_STAT);
  assign data_wr = reg_wr && (reg_addr == IDX_DATA);
  assign own_wr  = reg_wr && (reg_addr == IDX_OWN);

  assign start_wr  = stat_wr && reg_wdata[7] && reg_wdata[5] && reg_wdata[4];
  assign stop_wr   = stat_wr && reg_wdata[7] && !reg_wdata[5] && reg_wdata[4] && busy;
  assign launch    = ctrl_wr && pend && !reg_wdata[4];
  assign cmd_start = (start_wr && !busy) || (launch && (req == REQ_START));
  assign cmd_stop  = launch && (req == REQ_STOP);
  assign cmd_byte  = launch && (req == REQ_NONE);

  bhm_rate_gen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel), .div(div),
    .qtick(qtick)
  );

  bhm_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .qtick(qtick),
    .cmd_start(cmd_start), .cmd_byte(cmd_byte), .cmd_stop(cmd_stop),
    .cmd_data(data_q), .cmd_rx(mode == 2'b10), .cmd_ack_en(reg_wdata[7]),
    .sda_in(sda_in), .run(run), .busy(busy),
    .scl_low(scl_pull_low), .sda_low(sda_pull_low),
    .byte_done(byte_done), .done_rx(done_rx), .done_byte(done_byte),
    .done_ack(done_ack), .in_hold(in_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en <= 1'b0; pre_sel <= 1'b0; irq_en <= 1'b0; div <= '0;
      mode   <= 2'b00; txrx <= 1'b0; nack <= 1'b0;
      data_q <= 8'h00; own_q <= 8'h00;
    end else begin
      if (ctrl_wr) begin
        ack_en  <= reg_wdata[7];
        pre_sel <= reg_wdata[6];
        irq_en  <= reg_wdata[5];
        div     <= reg_wdata[DIV_W-1:0];
      end
      if (stat_wr) begin
        mode <= reg_wdata[7:6];
        txrx <= reg_wdata[4];
      end
      if (byte_done) nack <= done_ack;
      // A received byte takes the data register over a same-cycle write.
      if (byte_done && done_rx) data_q <= done_byte;
      else if (data_wr)         data_q <= reg_wdata;
      if (own_wr) own_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      req  <= REQ_NONE;
    end else begin
      if (byte_done)   pend <= 1'b1;
      else if (launch) pend <= 1'b0;
      if (start_wr && busy) req <= REQ_START;
      else if (stop_wr)     req <= REQ_STOP;
      else if (launch)      req <= REQ_NONE;
    end
  end

  assign irq = pend & irq_en;

  always_comb begin
    case (reg_addr)
      IDX_CTRL: reg_rdata = {ack_en, pre_sel, irq_en, pend, div};
      IDX_STAT: reg_rdata = {mode, busy, txrx, 3'b000, nack};
      IDX_DATA: reg_rdata = data_q;
      default:  reg_rdata = own_q;
    endcase
  end

  assert_hold_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (scl_pull_low && in_hold));

  assert_pend_after_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> pend);

  assert_sticky_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && ctrl_wr && reg_wdata[4]) |=> pend);

  assert_start_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[5] && !reg_wdata[4] && !busy) |=> !busy);

endmodule

// File: tb/bhm_i2c_master_bench.sv
module bhm_i2c_master_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, scl_pull_low, sda_pull_low;
  logic       s_drive = 1'b0;
  logic       scl_line, sda_line;

  assign scl_line = !scl_pull_low;
  assign sda_line = !(sda_pull_low | s_drive);

  bhm_i2c_master u_bhm_i2c_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low), .sda_in(sda_line)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, failed = 0;
  bit done = 0;

  // Behavioural slave and bus monitor.
  int   cyc = 0, starts = 0, stops = 0, bytes = 0, rises = 0, bitn = 0;
  int   last_rise = 0, period = 0, high_time = 0, bus_err = 0;
  logic [7:0] shift = 0, last_byte = 0;
  logic last_ack = 0, prev_scl = 1, prev_sda = 1;
  logic s_tx = 0, s_ack = 1;
  logic [7:0] s_byte = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (scl_line && prev_scl && (sda_line != prev_sda)) begin
        if (!sda_line) begin starts++; bitn = 0; end
        else stops++;
      end
      if (scl_line && !prev_scl) begin
        rises++;
        if (bitn < 8) begin
          shift = {shift[6:0], sda_line};
          if (bitn == 2) period = cyc - last_rise;
        end else begin
          last_byte = shift; last_ack = sda_line; bytes++;
        end
        last_rise = cyc;
        bitn = (bitn == 8) ? 0 : bitn + 1;
      end
      if (!scl_line && prev_scl) high_time = cyc - last_rise;
      if (!scl_line) begin
        if (bitn == 8) s_drive = !s_tx && s_ack;
        else           s_drive = s_tx && !s_byte[7-bitn];
      end
      if (irq && scl_line) bus_err++;
      prev_scl = scl_line;
      prev_sda = sda_line;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_pend(input string req);
    int k;
    for (k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (irq) break;
    end
    chk({req, " pending raised"}, int'(irq), 1);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] st;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      rd_reg(2'd1, st);
      if (!st[5]) break;
    end
    rd_reg(2'd1, st);
    chk({req, " busy cleared"}, int'(st[5]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 irq low", irq, 0);
    chk("R1 lines released", {scl_pull_low, sda_pull_low}, 0);

    // R12 own address
    wr_reg(2'd3, 8'h5A);
    rd_reg(2'd3, v);
    chk("R12 own address readback", v, 8'h5A);

    // R3 START + address byte, div 0, prescaler 16
    wr_reg(2'd0, 8'hA0);
    wr_reg(2'd2, 8'hA4);
    wr_reg(2'd1, 8'hF0);
    rd_reg(2'd1, v);
    chk("R3 busy after START", v[5], 1);
    wait_pend("R4");
    chk("R3 one START", starts, 1);
    chk("R3 address byte", last_byte, 8'hA4);
    chk("R2 period prescale 16 div 0", period, 16);
    chk("R2 high time", high_time, 8);
    rd_reg(2'd1, v);
    chk("R5 ACK seen", v[0], 0);
    rd_reg(2'd0, v);
    chk("R4 pending bit", v[4], 1);
    r0 = rises;
    repeat (40) @(negedge clk);
    chk("R4 SCL held low", scl_line, 0);

    // R6 writing 1 to pending launches nothing
    wr_reg(2'd0, 8'hB0);
    repeat (40) @(negedge clk);
    rd_reg(2'd0, v);
    chk("R6 pending still set", v[4], 1);
    chk("R6 no bus activity", rises, r0);

    // R7 transmit data byte
    wr_reg(2'd2, 8'h3C);
    wr_reg(2'd0, 8'hA0);
    wait_pend("R7");
    chk("R7 transmitted byte", last_byte, 8'h3C);

    // R5 NACK from slave
    s_ack = 0;
    wr_reg(2'd2, 8'h11);
    wr_reg(2'd0, 8'hA0);
    wait_pend("R5");
    chk("R5 byte before NACK", last_byte, 8'h11);
    rd_reg(2'd1, v);
    chk("R5 NACK flag", v[0], 1);
    s_ack = 1;

    // R8 repeated START, read address
    wr_reg(2'd2, 8'hA5);
    wr_reg(2'd1, 8'hB0);
    wr_reg(2'd0, 8'hA0);
    wait_pend("R8");
    chk("R8 second START", starts, 2);
    chk("R8 read address byte", last_byte, 8'hA5);

    // R11 collision: data writes every cycle until the received byte lands
    s_byte = 8'h96; s_tx = 1;
    wr_reg(2'd0, 8'hA0);
    for (int k = 0; k < 5000; k++) begin
      reg_addr = 2'd2; reg_wdata = 8'hEE; reg_wr = 1'b1;
      @(negedge clk);
      if (irq) break;
    end
    reg_wr = 1'b0;
    rd_reg(2'd2, v);
    chk("R11 received byte wins", v, 8'h96);
    chk("R7 master ACK on received byte", last_ack, 0);

    // R7 final byte with ACK generation cleared
    s_byte = 8'h5B;
    wr_reg(2'd0, 8'h20);
    wait_pend("R7");
    rd_reg(2'd2, v);
    chk("R7 second received byte", v, 8'h5B);
    chk("R7 master NACK", last_ack, 1);
    rd_reg(2'd1, v);
    chk("R5 NACK flag on final read", v[0], 1);

    // R9 STOP
    s_tx = 0; s_drive = 0;
    wr_reg(2'd1, 8'h90);
    wr_reg(2'd0, 8'h20);
    wait_idle("R9");
    chk("R9 one STOP", stops, 1);
    rd_reg(2'd0, v);
    chk("R9 pending stays clear", v[4], 0);
    chk("R9 SCL released", scl_line, 1);

    // R2 divisor 2, then prescaler 512
    wr_reg(2'd0, 8'hA2);
    wr_reg(2'd2, 8'h90);
    wr_reg(2'd1, 8'hF0);
    wait_pend("R2");
    chk("R2 period prescale 16 div 2", period, 48);
    chk("R2 high time div 2", high_time, 24);
    wr_reg(2'd2, 8'h77);
    wr_reg(2'd0, 8'hE0);
    wait_pend("R2");
    chk("R2 period prescale 512", period, 512);
    chk("R2 byte at slow rate", last_byte, 8'h77);
    wr_reg(2'd1, 8'hD0);
    wr_reg(2'd0, 8'hE0);
    wait_idle("R9");
    chk("R9 second STOP", stops, 2);

    // R10 START with TX/RX disabled
    r0 = starts;
    wr_reg(2'd0, 8'hA0);
    wr_reg(2'd1, 8'hE0);
    repeat (200) @(negedge clk);
    chk("R10 no START", starts, r0);
    rd_reg(2'd1, v);
    chk("R10 not busy", v[5], 0);
    chk("R10 bus idle", {scl_pull_low, sda_pull_low}, 0);

    chk("R4 per-clock SCL low while irq", bus_err, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule